// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog

This block is a watchdog timer that software drives only through key words written to one key register. A start key sets the down-counter running on a prescaled tick. A refresh key reloads it. Two further keys open and close write access to the three configuration registers: the prescaler select, the reload value and the window value. If the counter runs out, the block raises its reset output for one clock. Once started, no key can stop it.

A window value below all-ones turns on windowed operation. A refresh that arrives while the counter is still above the window value is treated as a fault, in the same way as an expiry. Configuration writes pass through a short settle stage. A per-register pending flag in the status register shows a value that has been written but is not yet in effect.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is idle and never pulses. Reads return 0 for the prescaler code (address 1), 0xFFF for the reload value (address 2), 0xFFF for the window value (address 3) and 0 for the status (address 4).
- R2: Writing key word 0x0000CCCC to address 0 starts the counter from the reload value. The first reset pulse comes (4 << code) * (reload + 1) cycles after the write edge.
- R3: Prescaler codes 0 to 6 divide the clock by 4, 8, 16, 32, 64, 128 and 256. Code 7 divides by 256.
- R4: On expiry the reset output is high for exactly one cycle. The counter then reloads and keeps running, so pulses repeat with the same period.
- R5: Writing key word 0x0000AAAA restarts the count from the reload value and prescaler phase zero. It also closes configuration write access.
- R6: Key word 0x00005555 opens configuration write access and 0x00000000 closes it. A configuration write while access is closed changes no readback value and sets no pending flag.
- R7: Status bits 0, 1 and 2 flag a pending prescaler, reload or window update. A flag sets on an accepted write and clears 4 cycles later. Until the flag clears, the old value stays in effect and is what a read returns.
- R8: With a window value other than 0xFFF, a refresh while the counter is above the window value gives a one-cycle reset pulse and reloads the counter. A refresh with the counter at or below the window value gives no pulse.
- R9: Once started, no key stops the watchdog. Only the block reset returns it to idle.
- R10: A key-register write with any word other than the four keys, including words whose upper bits are set, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 key, 1 prescaler, 2 reload, 3 window |
| wr_data_i | input | 32 | Write data word |
| rd_addr_i | input | 3 | Read address: 1 prescaler, 2 reload, 3 window, 4 status |
| rd_data_o | output | 32 | Combinational read data |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Internal state shows up at the ports in two ways. A wrong prescaler phase or wrong counter contents moves the reset pulse away from its predicted cycle, and the error is visible at the first expiry after a start or refresh, within one period. A wrong access-lock state or wrong pending-count state appears in the status and readback values a few cycles after the offending write. A wrong window comparison appears as a pulse that is present or missing on the cycle right after a refresh. The refreshes fall exactly on and just above the window boundary to expose off-by-one comparisons.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_LOCK    = 16'h0000;

  typedef enum logic [2:0] {
    A_KEY    = 3'd0,
    A_PRESC  = 3'd1,
    A_RELOAD = 3'd2,
    A_WINDOW = 3'd3,
    A_STATUS = 3'd4
  } reg_addr_e;

  localparam int unsigned N_CFG      = 3;
  localparam int unsigned CFG_PRESC  = 0;
  localparam int unsigned CFG_RELOAD = 1;
  localparam int unsigned CFG_WINDOW = 2;
endpackage

// File: rtl/kwdt_key_ctrl.sv
module kwdt_key_ctrl import kwdt_pkg::*; #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              started_o,
  output logic              unlocked_o,
  output logic              start_o,
  output logic              refresh_o
);
  logic is_start, is_refresh, is_unlock, is_lock;
  logic started_q, unlocked_q;

  assign is_start   = key_wr_i && (key_i == DATA_W'(KEY_START));
  assign is_refresh = key_wr_i && (key_i == DATA_W'(KEY_REFRESH));
  assign is_unlock  = key_wr_i && (key_i == DATA_W'(KEY_UNLOCK));
  assign is_lock    = key_wr_i && (key_i == DATA_W'(KEY_LOCK));

  assign start_o    = is_start && !started_q;
  assign refresh_o  = is_refresh && started_q;
  assign started_o  = started_q;
  assign unlocked_o = unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q  <= 1'b0;
      unlocked_q <= 1'b0;
    end else begin
      if (is_start) started_q <= 1'b1;
      if (is_unlock) unlocked_q <= 1'b1;
      else if (is_lock || is_refresh) unlocked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/kwdt_cfg_reg.sv
module kwdt_cfg_reg #(
  parameter int unsigned   W      = 12,
  parameter int unsigned   FW     = 12,
  parameter logic [W-1:0]  RST_V  = '1,
  parameter int unsigned   SETTLE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] val_o,
  output logic         pend_o
);
  localparam int unsigned  PW   = $clog2(SETTLE + 1);
  localparam logic [W-1:0] MASK = W'((64'd1 << FW) - 64'd1);

  logic [W-1:0]  shadow_q, val_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_V;
      val_q    <= RST_V;
      pcnt_q   <= '0;
    end else if (wr_i) begin
      shadow_q <= data_i & MASK;
      pcnt_q   <= PW'(SETTLE);
    end else if (pcnt_q != '0) begin
      pcnt_q <= pcnt_q - 1'b1;
      if (pcnt_q == PW'(1)) val_q <= shadow_q;
    end
  end

  assign val_o  = val_q;
  assign pend_o = (pcnt_q != '0);
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int unsigned PRE_W    = 3,
  parameter int unsigned MAX_CODE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             tick_o
);
  localparam int unsigned PCNT_W = MAX_CODE + 2;

  logic [PRE_W-1:0]  sel;
  logic [PCNT_W:0]   span;
  logic [PCNT_W-1:0] div_m1, pcnt_q;

  assign sel    = (code_i > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : code_i;
  assign span   = (PCNT_W+1)'(4) << sel;
  assign div_m1 = PCNT_W'(span - 1'b1);
  assign tick_o = run_i && !clr_i && (pcnt_q >= div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (clr_i || !run_i)   pcnt_q <= '0;
    else if (tick_o)            pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             refresh_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] window_i,
  output logic             wdt_rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             viol, expire, rst_q;

  assign viol   = refresh_i && (window_i != '1) && (cnt_q > window_i);
  assign expire = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      rst_q <= 1'b0;
    end else begin
      rst_q <= viol || expire;
      if (load_i)      cnt_q <= reload_i;
      else if (tick_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end

  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top import kwdt_pkg::*; #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PRE_W    = 3,
  parameter int unsigned MAX_CODE = 6,
  parameter int unsigned SETTLE   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wdt_rst_o
);
  logic key_wr, started, unlocked, start_p, refresh_p, load, tick;
  logic [N_CFG-1:0][CNT_W-1:0] cfg_val;
  logic [N_CFG-1:0]            pend;

  assign key_wr = wr_en_i && (wr_addr_i == A_KEY);
  assign load   = start_p || refresh_p;

  kwdt_key_ctrl #(.DATA_W(DATA_W)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_i      (wr_data_i),
    .started_o  (started),
    .unlocked_o (unlocked),
    .start_o    (start_p),
    .refresh_o  (refresh_p)
  );

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    localparam logic [CNT_W-1:0] RST_V = (g == CFG_PRESC) ? '0 : '1;
    localparam int unsigned      FW    = (g == CFG_PRESC) ? PRE_W : CNT_W;
    localparam logic [2:0]       ADDR  = 3'(g + 1);
    logic wr_g;
    assign wr_g = wr_en_i && unlocked && (wr_addr_i == ADDR);
    kwdt_cfg_reg #(.W(CNT_W), .FW(FW), .RST_V(RST_V), .SETTLE(SETTLE)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_g),
      .data_i (wr_data_i[CNT_W-1:0]),
      .val_o  (cfg_val[g]),
      .pend_o (pend[g])
    );
  end

  kwdt_prescaler #(.PRE_W(PRE_W), .MAX_CODE(MAX_CODE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (started),
    .clr_i  (load),
    .code_i (cfg_val[CFG_PRESC][PRE_W-1:0]),
    .tick_o (tick)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .refresh_i (refresh_p),
    .tick_i    (tick),
    .reload_i  (cfg_val[CFG_RELOAD]),
    .window_i  (cfg_val[CFG_WINDOW]),
    .wdt_rst_o (wdt_rst_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_PRESC:  rd_data_o = DATA_W'(cfg_val[CFG_PRESC]);
      A_RELOAD: rd_data_o = DATA_W'(cfg_val[CFG_RELOAD]);
      A_WINDOW: rd_data_o = DATA_W'(cfg_val[CFG_WINDOW]);
      A_STATUS: rd_data_o = DATA_W'(pend);
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        started,
  input logic        unlocked,
  input logic [2:0]  pend,
  input logic        wdt_rst_o
);
  logic key_wr, good_key;
  assign key_wr   = wr_en_i && (wr_addr_i == 3'd0);
  assign good_key = (wr_data_i == 32'h0000CCCC) || (wr_data_i == 32'h0000AAAA) ||
                    (wr_data_i == 32'h00005555) || (wr_data_i == 32'h00000000);

  // R9
  started_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |=> started);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> started);

  // R10
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && !good_key) |=> ($stable(unlocked) && $stable(started)));

  // R6
  locked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked && wr_addr_i == 3'd2 && !pend[1]) |=> !pend[1]);

  // R7
  accept_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unlocked && wr_addr_i == 3'd3) |=> pend[2]);

  // R5
  refresh_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wr_data_i == 32'h0000AAAA) |=> !unlocked);
endmodule

bind kwdt_top kwdt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .started   (started),
  .unlocked  (unlocked),
  .pend      (pend),
  .wdt_rst_o (wdt_rst_o)
);

// File: tb/kwdt_top_test.sv
`timescale 1ns/1ps
module kwdt_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        wdt_rst_o;
  int checks = 0;
  int errors = 0;

  kwdt_top uut (.*);

  always #2 clk_i = ~clk_i;

  // {code, reload, expected period in cycles}
  localparam logic [35:0] VEC [0:9] = '{
    {12'd0, 12'd2, 12'd12},  {12'd1, 12'd2, 12'd24},
    {12'd2, 12'd2, 12'd48},  {12'd3, 12'd2, 12'd96},
    {12'd4, 12'd2, 12'd192}, {12'd5, 12'd2, 12'd384},
    {12'd6, 12'd2, 12'd768}, {12'd7, 12'd2, 12'd768},
    {12'd0, 12'd0, 12'd4},   {12'd1, 12'd9, 12'd80}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!wdt_rst_o && n < lim);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    do_reset();
    // R1 reset state
    rd(3'd1, d); chk("R1 presc", d, 32'h0);
    rd(3'd2, d); chk("R1 reload", d, 32'hFFF);
    rd(3'd3, d); chk("R1 window", d, 32'hFFF);
    rd(3'd4, d); chk("R1 status", d, 32'h0);
    wait_pulse(40, n); chk("R1 idle no pulse", {31'd0, wdt_rst_o}, 32'd0);

    // R6 locked writes ignored
    wr(3'd2, 32'h7);
    rd(3'd4, d); chk("R6 locked no pending", d, 32'h0);
    settle(); rd(3'd2, d); chk("R6 locked reload", d, 32'hFFF);
    wr(3'd0, 32'h5555); wr(3'd0, 32'h0000); wr(3'd2, 32'h7);
    settle(); rd(3'd2, d); chk("R6 relocked reload", d, 32'hFFF);
    // R5 refresh key relocks
    wr(3'd0, 32'h5555); wr(3'd0, 32'hAAAA); wr(3'd2, 32'h7);
    settle(); rd(3'd2, d); chk("R5 refresh relocks", d, 32'hFFF);
    // R10 malformed keys do not unlock
    wr(3'd0, 32'h5556); wr(3'd0, 32'h0001_5555); wr(3'd2, 32'h7);
    settle(); rd(3'd2, d); chk("R10 bad unlock key", d, 32'hFFF);

    // R7 pending flag timing and deferred effect
    wr(3'd0, 32'h5555); wr(3'd3, 32'h100);
    rd(3'd4, d); chk("R7 window pending", d, 32'h4);
    rd(3'd3, d); chk("R7 old window held", d, 32'hFFF);
    repeat (3) @(negedge clk_i);
    rd(3'd4, d); chk("R7 still pending", d, 32'h4);
    @(negedge clk_i);
    rd(3'd4, d); chk("R7 pending cleared", d, 32'h0);
    rd(3'd3, d); chk("R7 new window", d, 32'h100);
    wr(3'd1, 32'hFFFF_FFF5);
    rd(3'd4, d); chk("R7 presc pending", d, 32'h1);
    settle(); rd(3'd1, d); chk("R7 presc masked", d, 32'h5);

    // R2 R3 R4 prescaler table
    foreach (VEC[i]) begin
      do_reset();
      wr(3'd0, 32'h5555);
      wr(3'd1, {20'd0, VEC[i][35:24]});
      wr(3'd2, {20'd0, VEC[i][23:12]});
      settle();
      wr(3'd0, 32'hCCCC);
      wait_pulse(2000, n);
      chk("R2 R3 first period", n, {20'd0, VEC[i][11:0]});
      @(negedge clk_i);
      chk("R4 one-cycle pulse", {31'd0, wdt_rst_o}, 32'd0);
      wait_pulse(2000, n);
      chk("R4 repeat period", n, {20'd0, VEC[i][11:0]} - 1);
    end

    // R10 bad start key, then R2 start, R9 no stop
    do_reset();
    wr(3'd0, 32'h5555); wr(3'd2, 32'h1); settle(); wr(3'd0, 32'h0000);
    wr(3'd0, 32'hCCCD);
    wait_pulse(30, n); chk("R10 bad start key ignored", {31'd0, wdt_rst_o}, 32'd0);
    wr(3'd0, 32'hCCCC);
    wait_pulse(50, n); chk("R2 start period", n, 32'd8);
    wr(3'd0, 32'h0000); wr(3'd0, 32'hCCCC); wr(3'd0, 32'h5555);
    wait_pulse(20, n); chk("R9 still running", {31'd0, wdt_rst_o}, 32'd1);

    // R5 refresh restarts count (window off)
    do_reset();
    wr(3'd0, 32'h5555); wr(3'd2, 32'd9); settle();
    wr(3'd0, 32'hCCCC);
    repeat (20) @(negedge clk_i);
    wr(3'd0, 32'hAAAA);
    chk("R5 no fault with window off", {31'd0, wdt_rst_o}, 32'd0);
    wait_pulse(200, n); chk("R5 period after refresh", n, 32'd40);

    // R8 window
    do_reset();
    wr(3'd0, 32'h5555); wr(3'd2, 32'd20); wr(3'd3, 32'd5); settle();
    wr(3'd0, 32'hCCCC);
    wr(3'd0, 32'hAAAA);
    chk("R8 early refresh fault", {31'd0, wdt_rst_o}, 32'd1);
    @(negedge clk_i);
    chk("R8 fault one cycle", {31'd0, wdt_rst_o}, 32'd0);
    repeat (69) @(negedge clk_i);
    wr(3'd0, 32'hAAAA);
    chk("R8 refresh inside window", {31'd0, wdt_rst_o}, 32'd0);
    repeat (61) @(negedge clk_i);
    wr(3'd0, 32'hAAAA);
    chk("R8 refresh at window value", {31'd0, wdt_rst_o}, 32'd0);
    repeat (57) @(negedge clk_i);
    wr(3'd0, 32'hAAAA);
    chk("R8 refresh one above window", {31'd0, wdt_rst_o}, 32'd1);
    wait_pulse(200, n); chk("R8 period after fault", n, 32'd84);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule